// File: doc/BRIEF.md
# Double-Buffered Dual-Channel DAC Code Register Interface

This block is the digital front end of a two-channel converter with 16-bit codes. A host on an asynchronous parallel bus writes a code into one of two staging registers, picked by a channel line, and can read either staging register back over the same bus. The two codes that feed the converters come from a second rank of registers. A rising edge on a load strobe copies both staging registers into that rank in the same clock cycle, so the two outputs always change together.

A rising edge on a clear input forces all four registers to one code. A parameter sets that code to mid-scale (only the MSB set) or to zero. All host lines are synchronised to the system clock and edge-detected before use. Write data and the channel line are taken while chip select is low, and the write is committed when chip select goes back high.

Top module: `dual_dac_regif`

## Requirements
- R1: While rst_ni is low and after it rises, both DAC outputs and both staging registers hold the reset code, and data_oe_o is low. The reset code is 0x8000 when ZERO_RESET=0 and 0x0000 when ZERO_RESET=1.
- R2: An access with cs_ni low and rw_i low is a write. Data is an unsigned binary word, bit 15 the MSB. On the rising edge of cs_ni the word is stored in staging register A if chsel_i was 0, or in staging register B if chsel_i was 1.
- R3: A write into a staging register leaves dac_a_o and dac_b_o unchanged until the next rising edge of load_i.
- R4: A rising edge of load_i copies both staging registers into dac_a_o and dac_b_o in the same cycle. A high level held on load_i, and a falling edge of load_i, do nothing.
- R5: While cs_ni is low with rw_i high, data_oe_o is high and data_o carries staging register A (chsel_i=0) or B (chsel_i=1). Otherwise data_oe_o is low and data_o is zero, which includes the time after cs_ni returns high.
- R6: While cs_ni is high, changes on rw_i, chsel_i and data_i alter no register.
- R7: A rising edge of clr_i sets both staging registers and both DAC outputs to the reset code.
- R8: A clear edge wins over a write commit or a load edge that lands in the same cycle.
- R9: If a write commit and a load edge land in the same cycle, the DAC register takes the newly written value.
- R10: A commit, load or clear shows on the outputs SYNC_STAGES+1 clock edges after the input edge. data_oe_o follows cs_ni and rw_i after SYNC_STAGES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host chip select, active low |
| rw_i | input | 1 | Access type: 1 read, 0 write |
| chsel_i | input | 1 | Channel: 0 register A, 1 register B |
| load_i | input | 1 | Load strobe, rising-edge active |
| clr_i | input | 1 | Clear to reset code, rising-edge active |
| data_i | input | 16 | Host write data |
| data_o | output | 16 | Host read data |
| data_oe_o | output | 1 | Tri-state enable for data_o |
| dac_a_o | output | 16 | Code for converter A |
| dac_b_o | output | 16 | Code for converter B |

## Verification
Every host line passes two synchroniser flops and an edge register. A commit, load or clear therefore shows on the registers at the third rising clock edge after the input changes, and read data with its enable shows at the second edge. The bench model keeps a short history of sampled inputs and reads it at those depths. It compares every output at each falling edge, half a period away from the updating edge. Directed checks sample at fixed counts of edges after each stimulus: one edge before the result is due, to see the old value, and then on the edge where it is due.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
  localparam int unsigned CH_N = 2;
  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} dac_ch_e;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dac_edge.sv
module dac_edge #(
  parameter int unsigned  W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/dac_host_port.sv
module dac_host_port
  import dac_regif_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_n_s_i,
  input  logic         rw_s_i,
  input  dac_ch_e      sel_s_i,
  input  logic [W-1:0] data_s_i,
  input  logic         cs_rise_i,
  input  logic [W-1:0] rd_a_i,
  input  logic [W-1:0] rd_b_i,
  output logic         wr_commit_o,
  output dac_ch_e      wr_sel_o,
  output logic [W-1:0] wr_data_o,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  logic pend_q;

  // capture while selected; the commit happens on deselect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      wr_sel_o  <= CH_A;
      wr_data_o <= '0;
    end else if (!cs_n_s_i) begin
      pend_q <= !rw_s_i;
      if (!rw_s_i) begin
        wr_sel_o  <= sel_s_i;
        wr_data_o <= data_s_i;
      end
    end
  end

  assign wr_commit_o = cs_rise_i & pend_q;
  assign data_oe_o   = !cs_n_s_i & rw_s_i;
  assign data_o      = !data_oe_o ? '0 : (sel_s_i == CH_B) ? rd_b_i : rd_a_i;
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_regif_pkg::*;
#(
  parameter int unsigned  W          = 16,
  parameter logic [W-1:0] RESET_CODE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_commit_i,
  input  dac_ch_e      wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         load_rise_i,
  input  logic         clr_rise_i,
  output logic [W-1:0] stage_o [CH_N],
  output logic [W-1:0] dac_o   [CH_N]
);
  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    logic         hit;
    logic [W-1:0] stage_nx;

    assign hit      = wr_commit_i && (wr_sel_i == dac_ch_e'(ch));
    assign stage_nx = hit ? wr_data_i : stage_o[ch];

    // clear first; a load sees the value committed in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_o[ch] <= RESET_CODE;
        dac_o[ch]   <= RESET_CODE;
      end else if (clr_rise_i) begin
        stage_o[ch] <= RESET_CODE;
        dac_o[ch]   <= RESET_CODE;
      end else begin
        stage_o[ch] <= stage_nx;
        if (load_rise_i) dac_o[ch] <= stage_nx;
      end
    end
  end
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
  import dac_regif_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          ZERO_RESET  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rw_i,
  input  logic              chsel_i,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o
);
  localparam logic [DATA_W-1:0] RESET_CODE =
    ZERO_RESET ? '0 : {1'b1, {(DATA_W-1){1'b0}}};
  localparam int unsigned CTL_W = 5;

  logic [CTL_W-1:0]  ctl_s;
  logic [DATA_W-1:0] data_s;
  logic [2:0]        rise;
  logic              cs_n_s, rw_s, load_s, clr_s;
  dac_ch_e           sel_s;
  logic              cs_rise, load_rise, clr_rise, wr_commit;
  dac_ch_e           wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] stage [CH_N];
  logic [DATA_W-1:0] dac   [CH_N];
  logic [DATA_W-1:0] in_a, in_b;

  dac_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b10000)) u_sync_ctl (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, rw_i, chsel_i, load_i, clr_i}),
    .q_o (ctl_s)
  );

  dac_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(data_s)
  );

  assign {cs_n_s, rw_s} = ctl_s[4:3];
  assign sel_s          = dac_ch_e'(ctl_s[2]);
  assign {load_s, clr_s} = ctl_s[1:0];

  dac_edge #(.W(3), .RST_VAL(3'b100)) u_edge (
    .clk_i, .rst_ni,
    .lvl_i  ({cs_n_s, load_s, clr_s}),
    .rise_o (rise)
  );
  assign {cs_rise, load_rise, clr_rise} = rise;

  dac_host_port #(.W(DATA_W)) u_host (
    .clk_i, .rst_ni,
    .cs_n_s_i    (cs_n_s),
    .rw_s_i      (rw_s),
    .sel_s_i     (sel_s),
    .data_s_i    (data_s),
    .cs_rise_i   (cs_rise),
    .rd_a_i      (in_a),
    .rd_b_i      (in_b),
    .wr_commit_o (wr_commit),
    .wr_sel_o    (wr_sel),
    .wr_data_o   (wr_data),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o)
  );

  dac_reg_bank #(.W(DATA_W), .RESET_CODE(RESET_CODE)) u_bank (
    .clk_i, .rst_ni,
    .wr_commit_i (wr_commit),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .load_rise_i (load_rise),
    .clr_rise_i  (clr_rise),
    .stage_o     (stage),
    .dac_o       (dac)
  );

  assign in_a    = stage[0];
  assign in_b    = stage[1];
  assign dac_a_o = dac[0];
  assign dac_b_o = dac[1];
endmodule

// File: rtl/dac_regif_chk.sv
module dac_regif_chk #(
  parameter int unsigned  W          = 16,
  parameter logic [W-1:0] RESET_CODE = '0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_rise,
  input logic         clr_rise,
  input logic         wr_commit,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [W-1:0] dac_a_o,
  input logic [W-1:0] dac_b_o,
  input logic [W-1:0] data_o,
  input logic         data_oe_o
);
  a_r3_dac_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_rise && !clr_rise |=> $stable(dac_a_o) && $stable(dac_b_o));

  a_r4_r9_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_rise && !clr_rise |=> dac_a_o == in_a && dac_b_o == in_b);

  a_r6_stage_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_commit && !clr_rise |=> $stable(in_a) && $stable(in_b));

  a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rise |=> in_a == RESET_CODE && in_b == RESET_CODE &&
                 dac_a_o == RESET_CODE && dac_b_o == RESET_CODE);

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rise && (wr_commit || load_rise) |=> in_a == RESET_CODE && dac_a_o == RESET_CODE);

  a_r5_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);
endmodule

bind dual_dac_regif dac_regif_chk #(.W(DATA_W), .RESET_CODE(RESET_CODE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_rise (load_rise),
  .clr_rise  (clr_rise),
  .wr_commit (wr_commit),
  .in_a      (in_a),
  .in_b      (in_b),
  .dac_a_o   (dac_a_o),
  .dac_b_o   (dac_b_o),
  .data_o    (data_o),
  .data_oe_o (data_oe_o)
);

// File: tb/dual_dac_regif_test.sv
module dual_dac_regif_test;
  localparam int unsigned W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b0, chsel = 1'b0, load = 1'b0, clr = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout, dout_z, dac_a, dac_b, dac_a_z, dac_b_z;
  logic oe, oe_z;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_dac_regif #(.DATA_W(W), .SYNC_STAGES(2), .ZERO_RESET(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw), .chsel_i(chsel),
    .load_i(load), .clr_i(clr), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .dac_a_o(dac_a), .dac_b_o(dac_b));

  dual_dac_regif #(.DATA_W(W), .SYNC_STAGES(2), .ZERO_RESET(1'b1)) uut_z (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rw_i(rw), .chsel_i(chsel),
    .load_i(load), .clr_i(clr), .data_i(din), .data_o(dout_z), .data_oe_o(oe_z),
    .dac_a_o(dac_a_z), .dac_b_o(dac_b_z));

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference: input history, two register images per variant
  logic [W-1:0] code [2] = '{16'h8000, 16'h0000};
  logic [W-1:0] m_in  [2][2];
  logic [W-1:0] m_dac [2][2];
  logic h_cs [4], h_rw [4], h_sel [4], h_ld [4], h_clr [4];
  logic [W-1:0] h_d [4];
  logic m_pend, m_psel;
  logic [W-1:0] m_pdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        h_cs[i] = 1'b1; h_rw[i] = 1'b0; h_sel[i] = 1'b0;
        h_ld[i] = 1'b0; h_clr[i] = 1'b0; h_d[i] = '0;
      end
      for (int k = 0; k < 2; k++)
        for (int c = 0; c < 2; c++) begin
          m_in[k][c] = code[k]; m_dac[k][c] = code[k];
        end
      m_pend = 1'b0; m_psel = 1'b0; m_pdata = '0;
    end else begin
      bit commit, ld_ev, clr_ev;
      for (int i = 3; i > 0; i--) begin
        h_cs[i] = h_cs[i-1]; h_rw[i] = h_rw[i-1]; h_sel[i] = h_sel[i-1];
        h_ld[i] = h_ld[i-1]; h_clr[i] = h_clr[i-1]; h_d[i] = h_d[i-1];
      end
      h_cs[0] = cs_n; h_rw[0] = rw; h_sel[0] = chsel;
      h_ld[0] = load; h_clr[0] = clr; h_d[0] = din;
      commit = h_cs[2] && !h_cs[3] && m_pend;
      ld_ev  = h_ld[2] && !h_ld[3];
      clr_ev = h_clr[2] && !h_clr[3];
      for (int k = 0; k < 2; k++) begin
        if (clr_ev) begin
          for (int c = 0; c < 2; c++) begin
            m_in[k][c] = code[k]; m_dac[k][c] = code[k];
          end
        end else begin
          if (commit) m_in[k][m_psel] = m_pdata;
          if (ld_ev) for (int c = 0; c < 2; c++) m_dac[k][c] = m_in[k][c];
        end
      end
      if (!h_cs[2]) begin
        m_pend = !h_rw[2];
        if (!h_rw[2]) begin m_psel = h_sel[2]; m_pdata = h_d[2]; end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    logic m_oe;
    m_oe = !h_cs[1] && h_rw[1];
    check("R10 model oe", {15'd0, oe}, {15'd0, m_oe});
    check("R10 model data", dout, m_oe ? m_in[0][h_sel[1]] : '0);
    check("R10 model data z", dout_z, m_oe ? m_in[1][h_sel[1]] : '0);
    check("R10 model dac a", dac_a, m_dac[0][0]);
    check("R10 model dac b", dac_b, m_dac[0][1]);
    check("R10 model dac a z", dac_a_z, m_dac[1][0]);
    check("R10 model dac b z", dac_b_z, m_dac[1][1]);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(logic sel, logic [W-1:0] val);
    cs_n = 1'b0; rw = 1'b0; chsel = sel; din = val;
    cyc(3);
    cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic host_read(logic sel, output logic [W-1:0] val, output logic en);
    cs_n = 1'b0; rw = 1'b1; chsel = sel;
    cyc(3);
    val = dout; en = oe;
    cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic pulse_load();
    load = 1'b1; cyc(3); load = 1'b0; cyc(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rv;
    logic en;
    cyc(3);
    check("R1 reset dac a", dac_a, 16'h8000);
    check("R1 reset dac b", dac_b, 16'h8000);
    check("R1 reset zero variant", dac_b_z, 16'h0000);
    check("R1 reset oe", {15'd0, oe}, 16'd0);
    rst_n = 1'b1;
    cyc(3);

    host_write(1'b0, 16'h1234);
    host_write(1'b1, 16'hABCD);
    check("R3 dac a unchanged by write", dac_a, 16'h8000);
    check("R3 dac b unchanged by write", dac_b, 16'h8000);
    host_read(1'b0, rv, en);
    check("R2 readback A", rv, 16'h1234);
    check("R5 oe during read", {15'd0, en}, 16'd1);
    host_read(1'b1, rv, en);
    check("R2 readback B", rv, 16'hABCD);
    check("R5 oe after read", {15'd0, oe}, 16'd0);
    check("R5 bus quiet after read", dout, 16'h0000);

    // load latency: new value due on the third edge
    load = 1'b1;
    cyc(2);
    check("R10 load not yet", dac_a, 16'h8000);
    cyc(1);
    check("R4 load a", dac_a, 16'h1234);
    check("R4 load b", dac_b, 16'hABCD);
    check("R4 load z variant", dac_b_z, 16'hABCD);

    host_write(1'b0, 16'h5555);
    cyc(3);
    check("R4 held level no load", dac_a, 16'h1234);
    load = 1'b0;
    cyc(4);
    check("R4 falling edge no load", dac_a, 16'h1234);
    pulse_load();
    check("R4 second load", dac_a, 16'h5555);

    // bus activity with chip select high
    rw = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chsel = i[0]; din = 16'h0F00 + 16'(i); cyc(1);
    end
    cyc(4);
    host_read(1'b0, rv, en);
    check("R6 A untouched", rv, 16'h5555);
    host_read(1'b1, rv, en);
    check("R6 B untouched", rv, 16'hABCD);

    // commit and load on the same edge
    cs_n = 1'b0; rw = 1'b0; chsel = 1'b1; din = 16'h0F0F;
    cyc(3);
    cs_n = 1'b1; load = 1'b1;
    cyc(2);
    check("R10 commit not yet", dac_b, 16'hABCD);
    cyc(1);
    check("R9 same-cycle write then load", dac_b, 16'h0F0F);
    load = 1'b0;
    cyc(4);

    clr = 1'b1;
    cyc(2);
    check("R10 clear not yet", dac_a, 16'h5555);
    cyc(1);
    check("R7 clear dac a", dac_a, 16'h8000);
    check("R7 clear dac b", dac_b, 16'h8000);
    check("R7 clear zero variant", dac_a_z, 16'h0000);
    clr = 1'b0;
    cyc(3);
    host_read(1'b1, rv, en);
    check("R7 clear staging B", rv, 16'h8000);

    // clear collides with commit and load
    host_write(1'b0, 16'hFFFF);
    pulse_load();
    cs_n = 1'b0; rw = 1'b0; chsel = 1'b0; din = 16'h7777;
    cyc(3);
    cs_n = 1'b1; load = 1'b1; clr = 1'b1;
    cyc(4);
    check("R8 clear beats load", dac_a, 16'h8000);
    host_read(1'b0, rv, en);
    check("R8 clear beats commit", rv, 16'h8000);
    load = 1'b0; clr = 1'b0;
    cyc(4);

    host_write(1'b0, 16'hFFFF);
    host_write(1'b1, 16'h0000);
    pulse_load();
    check("R2 full scale a", dac_a, 16'hFFFF);
    check("R2 zero b", dac_b, 16'h0000);
    cyc(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule